// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that works through a list of transfer descriptors kept in system memory. Each descriptor is 32 bytes long. It tells the channel where to read, where to write, how many bytes to move, which options apply and where the following descriptor sits. Software writes the address of the first descriptor and then sets the run bit. From that point the channel fetches each descriptor and copies one 32-bit word per read/write pair. It then follows the link to the next descriptor.

A peripheral request line can pace the copy, so a slow device sets the rate. Each descriptor can raise an interrupt when it completes. A link that points back to an earlier descriptor forms an endless ring, which suits streaming buffers such as audio. Software can pause the channel, abandon the current descriptor and move to the next one, or return the channel to its reset state. It can also read the live source and destination pointers to work out how much data remains.

Top module: `cbdma_channel`

## Requirements
- R1: After reset, status (offset 0x00) reads 0x10: not running, paused/idle bit 4 set, no interrupt, no error. All address registers read 0 and `irq` is low.
- R2: Write the descriptor address at offset 0x04, then write status with bit 0 = 1. The channel reads six words from descriptor base + 0, 4, 8, 12, 16, 20:
  - info
  - source
  - destination
  - length in bytes
  - stride (ignored)
  - next-descriptor address

  The source, destination and next values become readable at 0x0C, 0x10 and 0x1C.
- R3: Each word is read from the current source and then written to the current destination. After each word the length drops by 4. Source advances by 4 when info bit 8 is set, and destination advances by 4 when info bit 4 is set. Both registers show the updated values after every word.
- R4: A descriptor ends when its length reaches zero. If info bit 0 is set, status bit 2 and `irq` go high. If the next address is 0, status bit 0 clears and the channel goes idle.
- R5: A nonzero next address is loaded into the descriptor register (0x04) and that descriptor is fetched. A link back to an earlier descriptor repeats forever.
- R6: Status bit 2 clears when 1 is written to it. One write of 0x5 clears the interrupt and keeps the channel running.
- R7: When info bit 10 or bit 6 is set, a word starts only while `dreq[info[16 +: clog2(N_DREQ)]]` is high. While the line is low, no memory access happens, status bit 5 reads 1 and the address registers hold their values.
- R8: Writing status bit 0 = 0 lets the current memory beat finish and then starts no new beat. Status bit 4 then reads 1. Writing 1 again resumes the copy with no word lost or repeated.
- R9: Writing status bit 30 between words ends the current descriptor without an interrupt and moves to the next descriptor. If the next address (writable at 0x1C) is 0, the channel stops instead.
- R10: A read that returns `mem_err` sets status bit 8 and clears bit 0. The channel issues no further access.
- R11: Writing status bit 31 puts every register back to its R1 state. Bit 31 always reads 0.
- R12: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable from the start of a beat until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Beat completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Read error, valid with `mem_ready` |
| dreq | input | N_DREQ | Peripheral request lines |
| irq | output | 1 | Completion interrupt (status bit 2) |

## Verification
The bench builds the channel with N_DREQ = 8, so the line-select field is three bits wide starting at bit 16. Line 3 can therefore be held low while a different line is driven high, which checks that only the selected line lets a paced descriptor proceed. The memory model's wait-state count is raised for the ring and pause scenarios. This stretches each descriptor over enough cycles for status reads to land reliably between completions and between individual beats.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE} cb_state_e;

  // descriptor info word fields
  localparam int INFO_INTEN    = 0;
  localparam int INFO_DINC     = 4;
  localparam int INFO_DPACE    = 6;
  localparam int INFO_SINC     = 8;
  localparam int INFO_SPACE    = 10;
  localparam int INFO_LINE_LSB = 16;

  // status word command bits
  localparam int CS_RUN   = 0;
  localparam int CS_IRQ   = 2;
  localparam int CS_ABORT = 30;
  localparam int CS_RESET = 31;

  localparam logic [4:0] OFS_CS   = 5'h00;
  localparam logic [4:0] OFS_CB   = 5'h04;
  localparam logic [4:0] OFS_SRC  = 5'h0C;
  localparam logic [4:0] OFS_DST  = 5'h10;
  localparam logic [4:0] OFS_NEXT = 5'h1C;

  localparam logic [2:0] LAST_FETCH_IDX = 3'd5;

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a, input logic inc);
    return inc ? a + WORD_W'(4) : a;
  endfunction

  function automatic logic [WORD_W-1:0] desc_word_addr(input logic [WORD_W-1:0] base,
                                                       input logic [2:0] idx);
    return base + {{(WORD_W-5){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic run, input logic intf,
                                                    input logic paused, input logic held,
                                                    input logic err);
    return {23'd0, err, 2'b00, held, paused, 1'b0, intf, 1'b0, run};
  endfunction
endpackage

// File: rtl/cbdma_dreq_sel.sv
module cbdma_dreq_sel #(
  parameter int N_LINES = 32,
  localparam int SEL_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] dreq,
  input  logic [SEL_W-1:0]   sel,
  output logic               ready
);
  generate
    if (N_LINES == (1 << SEL_W)) begin : g_direct
      assign ready = dreq[sel];
    end else begin : g_search
      always_comb begin
        ready = 1'b0;
        for (int i = 0; i < N_LINES; i++)
          if (sel == SEL_W'(i)) ready = dreq[i];
      end
    end
  endgenerate
endmodule

// File: rtl/cbdma_core.sv
module cbdma_core
  import cbdma_pkg::*;
#(
  parameter int N_DREQ = 32,
  localparam int LINE_W = $clog2(N_DREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cs_we,
  input  logic              cmd_run,
  input  logic              cmd_irq_clr,
  input  logic              cmd_abort,
  input  logic              cmd_reset,
  input  logic              cmd_cb_we,
  input  logic              cmd_next_we,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              line_ready,
  output logic [LINE_W-1:0] line_sel,
  output logic              run_o,
  output logic              int_o,
  output logic              err_o,
  output logic              held_o,
  output logic              paused_o,
  output logic [WORD_W-1:0] cb_o,
  output logic [WORD_W-1:0] src_o,
  output logic [WORD_W-1:0] dst_o,
  output logic [WORD_W-1:0] next_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err
);
  cb_state_e         st_q;
  logic [2:0]        fidx_q;
  logic              beat_q, run_q, int_q, err_q, abort_q;
  logic              inten_q, sinc_q, dinc_q, pace_q;
  logic [LINE_W-1:0] line_q;
  logic [WORD_W-1:0] src_q, dst_q, len_q, next_q, cb_q, data_q;

  // named internal events
  logic soft_rst, stall, abort_take, beat_done, rd_fail, fetch_last, word_last;
  logic blk_done, blk_done_int, can_launch;
  logic [WORD_W-1:0] next_eff;

  assign soft_rst     = cmd_cs_we && cmd_reset;
  assign stall        = (st_q == ST_READ) && pace_q && !line_ready;
  assign abort_take   = abort_q && !beat_q && (st_q == ST_READ || st_q == ST_WRITE);
  assign beat_done    = beat_q && mem_ready;
  assign rd_fail      = beat_done && !mem_we && mem_err;
  assign fetch_last   = beat_done && !mem_err && st_q == ST_FETCH && fidx_q == LAST_FETCH_IDX;
  assign word_last    = beat_done && st_q == ST_WRITE && len_q <= WORD_W'(4);
  assign blk_done     = word_last || abort_take || (fetch_last && len_q == '0);
  assign blk_done_int = (word_last || (fetch_last && len_q == '0)) && inten_q;
  assign next_eff     = (st_q == ST_FETCH) ? mem_rdata : next_q;
  assign can_launch   = st_q != ST_IDLE && !beat_q && run_q && !stall && !abort_take;

  assign held_o   = !beat_q && run_q && stall;
  assign paused_o = !run_q && !beat_q;
  assign run_o    = run_q;
  assign int_o    = int_q;
  assign err_o    = err_q;
  assign cb_o     = cb_q;
  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign next_o   = next_q;
  assign line_sel = line_q;

  assign mem_req   = beat_q;
  assign mem_we    = st_q == ST_WRITE;
  assign mem_wdata = data_q;
  always_comb begin
    unique case (st_q)
      ST_FETCH: mem_addr = desc_word_addr(cb_q, fidx_q);
      ST_READ:  mem_addr = src_q;
      default:  mem_addr = dst_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      st_q <= ST_IDLE; fidx_q <= '0; beat_q <= 1'b0; run_q <= 1'b0; int_q <= 1'b0;
      err_q <= 1'b0; abort_q <= 1'b0; inten_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
      pace_q <= 1'b0; line_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
      next_q <= '0; cb_q <= '0; data_q <= '0;
    end else begin
      // software commands first, engine events below take precedence
      if (cmd_cs_we) begin
        run_q <= cmd_run;
        if (cmd_irq_clr) int_q <= 1'b0;
        if (cmd_abort && st_q != ST_IDLE) abort_q <= 1'b1;
        if (cmd_run && st_q == ST_IDLE) begin
          st_q   <= ST_FETCH;
          fidx_q <= '0;
        end
      end
      if (cmd_cb_we && st_q == ST_IDLE) cb_q <= cmd_wdata;
      if (cmd_next_we) next_q <= cmd_wdata;

      if (can_launch) beat_q <= 1'b1;
      if (beat_done) beat_q <= 1'b0;

      if (rd_fail) begin
        err_q <= 1'b1;
        run_q <= 1'b0;
        st_q  <= ST_IDLE;
      end else if (beat_done) begin
        unique case (st_q)
          ST_FETCH: begin
            unique case (fidx_q)
              3'd0: begin
                inten_q <= mem_rdata[INFO_INTEN];
                dinc_q  <= mem_rdata[INFO_DINC];
                sinc_q  <= mem_rdata[INFO_SINC];
                pace_q  <= mem_rdata[INFO_SPACE] | mem_rdata[INFO_DPACE];
                line_q  <= mem_rdata[INFO_LINE_LSB +: LINE_W];
              end
              3'd1: src_q  <= mem_rdata;
              3'd2: dst_q  <= mem_rdata;
              3'd3: len_q  <= mem_rdata;
              3'd5: next_q <= mem_rdata;
              default: ;
            endcase
            fidx_q <= fidx_q + 3'd1;
            if (fidx_q == LAST_FETCH_IDX) st_q <= ST_READ;
          end
          ST_READ: begin
            data_q <= mem_rdata;
            st_q   <= ST_WRITE;
          end
          ST_WRITE: begin
            src_q <= step_addr(src_q, sinc_q);
            dst_q <= step_addr(dst_q, dinc_q);
            len_q <= len_q - WORD_W'(4);
            st_q  <= ST_READ;
          end
          default: ;
        endcase
      end

      if (blk_done) begin
        abort_q <= 1'b0;
        if (blk_done_int) int_q <= 1'b1;
        if (next_eff == '0) begin
          st_q  <= ST_IDLE;
          run_q <= 1'b0;
        end else begin
          cb_q   <= next_eff;
          st_q   <= ST_FETCH;
          fidx_q <= '0;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q && !mem_ready && !soft_rst |=> beat_q && $stable(mem_addr) && $stable(mem_we)
                                          && $stable(mem_wdata));
  p_held_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    held_o && !soft_rst |=> $stable(src_q) && $stable(dst_q));
  p_idle_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_IDLE |-> !mem_req);
  p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail && !soft_rst |=> err_q && !run_q && !mem_req);
  p_chain_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && next_eff == '0 && !soft_rst |=> !run_q);
  p_int_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_int && !soft_rst |=> int_q);
  p_abort_noint_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take && !int_q && !soft_rst |=> !int_q);
endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
  import cbdma_pkg::*;
#(
  parameter int N_DREQ = 32,
  localparam int LINE_W = $clog2(N_DREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  input  logic [N_DREQ-1:0] dreq,
  output logic              irq
);
  logic              run_s, int_s, err_s, held_s, paused_s, line_ok;
  logic [LINE_W-1:0] line_sel;
  logic [WORD_W-1:0] cb_s, src_s, dst_s, next_s;
  logic              cs_we;

  assign cs_we = reg_we && reg_addr == OFS_CS;

  cbdma_dreq_sel #(.N_LINES(N_DREQ)) u_sel (
    .dreq(dreq), .sel(line_sel), .ready(line_ok));

  cbdma_core #(.N_DREQ(N_DREQ)) u_core (
    .clk(clk), .rst_n(rst_n),
    .cmd_cs_we(cs_we), .cmd_run(reg_wdata[CS_RUN]), .cmd_irq_clr(reg_wdata[CS_IRQ]),
    .cmd_abort(reg_wdata[CS_ABORT]), .cmd_reset(reg_wdata[CS_RESET]),
    .cmd_cb_we(reg_we && reg_addr == OFS_CB), .cmd_next_we(reg_we && reg_addr == OFS_NEXT),
    .cmd_wdata(reg_wdata), .line_ready(line_ok), .line_sel(line_sel),
    .run_o(run_s), .int_o(int_s), .err_o(err_s), .held_o(held_s), .paused_o(paused_s),
    .cb_o(cb_s), .src_o(src_s), .dst_o(dst_s), .next_o(next_s),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err));

  assign irq = int_s;

  always_comb begin
    unique case (reg_addr)
      OFS_CS:   reg_rdata = pack_status(run_s, int_s, paused_s, held_s, err_s);
      OFS_CB:   reg_rdata = cb_s;
      OFS_SRC:  reg_rdata = src_s;
      OFS_DST:  reg_rdata = dst_s;
      OFS_NEXT: reg_rdata = next_s;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/cbdma_channel_tb.sv
module cbdma_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_DREQ = 8;
  localparam logic [4:0] A_CS = 5'h00, A_CB = 5'h04, A_SRC = 5'h0C, A_DST = 5'h10, A_NEXT = 5'h1C;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ready = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [N_DREQ-1:0] dreq = 0;
  logic irq;

  int checks = 0, fails = 0;
  int lat = 1, wcnt = 0, wr_count = 0, proto_bad = 0;
  logic err_en = 0;
  logic [31:0] err_addr = 0;
  logic pend_we = 0, tracking = 0;
  logic [31:0] pend_addr = 0, pend_wdata = 0, track_addr = 0;
  logic [31:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  cbdma_channel #(.N_DREQ(N_DREQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .dreq(dreq), .irq(irq));

  // memory model: answers on the falling edge, commits writes one cycle later
  always @(negedge clk) begin
    if (mem_ready) begin
      if (pend_we) begin
        mem[pend_addr[9:2]] = pend_wdata;
        wr_count++;
      end
      mem_ready = 0;
      mem_err = 0;
    end else if (mem_req) begin
      if (!tracking) begin
        tracking = 1;
        track_addr = mem_addr;
      end else if (mem_addr != track_addr) proto_bad++;
      if (wcnt >= lat) begin
        mem_ready = 1;
        pend_we = mem_we;
        pend_addr = mem_addr;
        pend_wdata = mem_wdata;
        mem_rdata = mem[mem_addr[9:2]];
        mem_err = !mem_we && err_en && mem_addr == err_addr;
        wcnt = 0;
        tracking = 0;
      end else wcnt++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] cs;
    for (int n = 0; n < 3000; n++) begin
      rd(A_CS, cs);
      if (!cs[0]) return;
    end
  endtask

  task automatic wait_irq();
    for (int n = 0; n < 3000 && !irq; n++) @(negedge clk);
  endtask

  task automatic put_desc(input int base, input logic [31:0] info, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] len, input logic [31:0] nxt);
    mem[base/4] = info; mem[base/4+1] = s; mem[base/4+2] = d;
    mem[base/4+3] = len; mem[base/4+4] = 0; mem[base/4+5] = nxt;
  endtask

  task automatic fill(input int base, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) mem[base/4+i] = seed + i;
  endtask

  task automatic clear(input int base, input int n);
    for (int i = 0; i < n; i++) mem[base/4+i] = SENT;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CS, v);  chk("R1 status", v, 32'h10);
    rd(A_SRC, v); chk("R1 src", v, 0);
    rd(A_CB, v);  chk("R1 cb", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int w0;
    put_desc(32'h100, 32'h111, 32'h200, 32'h300, 16, 0);
    fill(32'h200, 4, 32'hA000_0000); clear(32'h300, 4);
    w0 = wr_count;
    wr(A_CB, 32'h100); wr(A_CS, 1); wait_idle();
    for (int i = 0; i < 4; i++) chk("R3 copied word", mem[32'h300/4+i], 32'hA000_0000 + i);
    chk("R3 write count", wr_count - w0, 4);
    rd(A_SRC, v); chk("R3 src advanced", v, 32'h210);
    rd(A_DST, v); chk("R3 dst advanced", v, 32'h310);
    rd(A_CB, v);  chk("R2 cb register", v, 32'h100);
    rd(A_NEXT, v); chk("R2 next loaded", v, 0);
    rd(A_CS, v);  chk("R4 done status", v, 32'h14);
    chk("R4 irq", {31'd0, irq}, 1);
    wr(A_CS, 32'h4);
    rd(A_CS, v);  chk("R6 w1c", v, 32'h10);
    chk("R6 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    put_desc(32'h100, 32'h111, 32'h200, 32'h300, 8, 32'h120);
    put_desc(32'h120, 32'h100, 32'h240, 32'h3F0, 12, 0);
    fill(32'h240, 3, 32'hB0); clear(32'h3F0, 1);
    wr(A_CB, 32'h100); wr(A_CS, 1); wait_idle();
    chk("R3 fixed dst last word", mem[32'h3F0/4], 32'hB2);
    rd(A_CB, v);  chk("R5 cb follows link", v, 32'h120);
    rd(A_DST, v); chk("R3 dst not incremented", v, 32'h3F0);
    rd(A_SRC, v); chk("R3 src of second block", v, 32'h24C);
    rd(A_CS, v);  chk("R4 chain status", v, 32'h14);
    wr(A_CS, 32'h4);
  endtask

  task automatic t_pace();
    logic [31:0] v;
    int w0;
    put_desc(32'h100, 32'h30510, 32'h200, 32'h300, 8, 0);
    fill(32'h200, 2, 32'hC0); clear(32'h300, 2);
    dreq = 0; w0 = wr_count;
    wr(A_CB, 32'h100); wr(A_CS, 1);
    repeat (30) @(negedge clk);
    rd(A_CS, v);  chk("R7 held status", v, 32'h21);
    rd(A_SRC, v); chk("R7 src frozen", v, 32'h200);
    chk("R7 no writes", wr_count - w0, 0);
    dreq[2] = 1;
    repeat (20) @(negedge clk);
    rd(A_CS, v);  chk("R7 other line ignored", v, 32'h21);
    dreq[3] = 1;
    wait_idle();
    chk("R7 paced word 1", mem[32'h304/4], 32'hC1);
    rd(A_CS, v);  chk("R7 paced done", v, 32'h10);
    dreq = 0;
  endtask

  task automatic t_abort();
    logic [31:0] v;
    put_desc(32'h100, 32'h30510, 32'h200, 32'h300, 8, 32'h140);
    put_desc(32'h140, 32'h111, 32'h220, 32'h380, 4, 0);
    fill(32'h220, 1, 32'hD0); clear(32'h300, 2); clear(32'h380, 1);
    wr(A_CB, 32'h100); wr(A_CS, 1);
    repeat (30) @(negedge clk);
    wr(A_CS, 32'h4000_0001); wait_idle();
    chk("R9 next block ran", mem[32'h380/4], 32'hD0);
    chk("R9 aborted block wrote nothing", mem[32'h300/4], SENT);
    rd(A_CB, v); chk("R9 moved to next", v, 32'h140);
    rd(A_CS, v); chk("R9 next block interrupt", v, 32'h14);
    wr(A_CS, 32'h4);
    wr(A_CB, 32'h100); wr(A_CS, 1);
    repeat (30) @(negedge clk);
    wr(A_NEXT, 0); wr(A_CS, 32'h4000_0001); wait_idle();
    rd(A_CS, v); chk("R9 abort stops, no interrupt", v, 32'h10);
    chk("R9 no data after stop", mem[32'h300/4], SENT);
  endtask

  task automatic t_cyclic();
    logic [31:0] v;
    lat = 3;
    put_desc(32'h180, 32'h111, 32'h200, 32'h300, 4, 32'h1A0);
    put_desc(32'h1A0, 32'h111, 32'h204, 32'h304, 4, 32'h180);
    fill(32'h200, 2, 32'hE0);
    wr(A_CB, 32'h180); wr(A_CS, 1);
    wait_irq();
    rd(A_CB, v); chk("R5 ring advance", v, 32'h1A0);
    wr(A_CS, 32'h5);
    rd(A_CS, v); chk("R6 clear and keep running", v & 32'h5, 32'h1);
    wait_irq();
    rd(A_CB, v); chk("R5 ring wraps", v, 32'h180);
    chk("R5 ring second word", mem[32'h304/4], 32'hE1);
    wr(A_CS, 0);
    repeat (10) @(negedge clk);
    wr(A_CS, 32'h8000_0000);
    rd(A_CS, v);  chk("R11 soft reset status", v, 32'h10);
    rd(A_SRC, v); chk("R11 soft reset src", v, 0);
    rd(A_CB, v);  chk("R11 soft reset cb", v, 0);
    lat = 1;
  endtask

  task automatic t_pause();
    logic [31:0] v, s1;
    int w0, w1;
    logic ok;
    lat = 2;
    put_desc(32'h100, 32'h111, 32'h200, 32'h300, 32, 0);
    fill(32'h200, 8, 32'hF00); clear(32'h300, 8);
    w0 = wr_count;
    wr(A_CB, 32'h100); wr(A_CS, 1);
    repeat (40) @(negedge clk);
    wr(A_CS, 0);
    repeat (10) @(negedge clk);
    rd(A_CS, v); chk("R8 paused status", v & 32'h11, 32'h10);
    rd(A_SRC, s1); w1 = wr_count;
    repeat (30) @(negedge clk);
    rd(A_SRC, v); chk("R8 src frozen while paused", v, s1);
    chk("R8 no writes while paused", wr_count - w1, 0);
    wr(A_CS, 1); wait_idle();
    ok = 1;
    for (int i = 0; i < 8; i++) if (mem[32'h300/4+i] !== 32'hF00 + i) ok = 0;
    chk("R8 all words after resume", {31'd0, ok}, 1);
    chk("R8 no duplicate writes", wr_count - w0, 8);
    wr(A_CS, 32'h4);
    lat = 1;
  endtask

  task automatic t_error();
    logic [31:0] v;
    put_desc(32'h100, 32'h111, 32'h200, 32'h300, 12, 0);
    fill(32'h200, 3, 32'h700); clear(32'h300, 3);
    err_en = 1; err_addr = 32'h204;
    wr(A_CB, 32'h100); wr(A_CS, 1); wait_idle();
    rd(A_CS, v); chk("R10 error status", v, 32'h110);
    chk("R10 word before error", mem[32'h300/4], 32'h700);
    chk("R10 no write after error", mem[32'h304/4], SENT);
    chk("R10 no irq", {31'd0, irq}, 0);
    err_en = 0;
    wr(A_CS, 32'h8000_0000);
    rd(A_CS, v); chk("R11 reset clears error", v, 32'h10);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_chain();
    t_pace();
    t_abort();
    t_cyclic();
    t_pause();
    t_error();
    chk("R12 request held stable", proto_bad, 0);
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule